// File: doc/BRIEF.md
# Frame Descriptor Fetch Sequencer

This block loads the per-frame DMA descriptors for a display controller with up to seven fetch channels. A `frame_start` pulse starts a walk over the channels in ascending order. A channel that is not active is skipped, and its source register is cleared. For an active channel, the block picks the descriptor pointer from one of two places. If the one-shot branch register is armed, the pointer comes from there. Otherwise it is the next-descriptor address stored by the previous fetch. The block then checks that the whole four-word descriptor lies inside the valid memory window. If it does, the block reads the four words one at a time over a simple request/response memory port.

The fetched words update the channel's next-descriptor, source, frame-ID and command registers. After the fetch, the block checks the source address. An invalid source raises a bus-error event. A valid source whose command requests a palette load raises a palette event instead. When an armed branch is consumed, its active flag clears, and it raises a branch event if its interrupt bit is set. All events are single-cycle pulses tagged with the channel number, for an external interrupt block.

Software reaches the registers through a word write port and a combinational read port. The activity of each channel follows the display, dual-scan, overlay and cursor enable inputs.

Top module: `fdesc_sequencer`

## Requirements
- R1: After reset every channel register reads 0, `busy`, `done` and all event outputs are 0, and no memory request is made.
- R2: For an active channel with a usable pointer P, the block reads the words at P, P+4, P+8 and P+12, one request at a time. It stores them as next-descriptor, source, frame ID and command. These read back at 0x200+16*ch plus offsets 0x0, 0x4, 0x8 and 0xC respectively.
- R3: An inactive channel makes no memory request and its source register becomes 0.
- R4: The branch register of channel ch sits at 0x040+4*ch. Bit 0 arms it, bit 1 requests an event, and bits 31:4 hold the pointer. When armed, the fetch uses the pointer and bit 0 is cleared. If bit 1 is set, `evt_branch` pulses with `evt_chan`=ch. Bit 1 and the pointer bits are kept.
- R5: Without an armed branch, the stored next-descriptor address is used, so successive frames follow the descriptor chain.
- R6: A pointer P is fetched only if P >= MEM_BASE and P+16 <= MEM_BASE+MEM_SIZE. Otherwise the channel makes no request, its source stays 0, and a bus error follows.
- R7: Writes to a next-descriptor register keep only bits 31:4 (mask 0xfffffff0). Writes to a branch register are masked with 0xfffffff3.
- R8: After an active channel is handled, `evt_buserr` pulses if its source is 0 or its source is outside [MEM_BASE, MEM_BASE+MEM_SIZE] (both ends inclusive). Otherwise `evt_palette` pulses if command bit 26 is set. Bits 20:2 of the command hold a byte length, bit 21 enables the end-of-frame interrupt, and bit 22 enables the start-of-frame interrupt; all of these are stored without effect here.
- R9: Channel 0 is active with `lcd_enable`. Channel 1 is active with `ovl1_enable` or `dual_scan`. Channels 2 to 4 are active with `ovl2_enable`, channel 5 with `cursor_enable`, and channel 6 never.
- R10: Channels are handled strictly in ascending order. At most one event pulses per cycle. `done` pulses once, with `busy` low, when the last channel has been handled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| frame_start | input | 1 | Starts a descriptor walk when idle |
| lcd_enable | input | 1 | Controller enable, drives channel 0 activity |
| dual_scan | input | 1 | Dual-scan enable, drives channel 1 activity |
| ovl1_enable | input | 1 | Overlay 1 enable, drives channel 1 activity |
| ovl2_enable | input | 1 | Overlay 2 enable, drives channels 2 to 4 |
| cursor_enable | input | 1 | Cursor enable, drives channel 5 |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | AW | Register write address |
| reg_wdata | input | 32 | Register write data |
| reg_raddr | input | AW | Register read address |
| reg_rdata | output | 32 | Register read data, 0 for unmapped addresses |
| mem_req | output | 1 | One-cycle word read request |
| mem_addr | output | 32 | Word read address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | Pulse when the walk ends |
| evt_branch | output | 1 | Branch consumed with event requested |
| evt_buserr | output | 1 | Bus error on the channel |
| evt_palette | output | 1 | Palette load requested by the channel |
| evt_chan | output | CW | Channel of the current event |

## Verification
The bench builds the block with a 4 KiB window at MEM_BASE=0x1000 and a bench memory of 1024 words that covers the window exactly. With this small window, both window edges can be reached directly. A descriptor ending exactly at the top edge, a pointer at the top edge, and a pointer just below the base are all exercised, as are source addresses equal to and just past the inclusive upper bound. The default seven channels bring the full enable-to-channel mapping and the ordering of bus-error events within reach.

// File: rtl/fdesc_sequencer.sv
module fdesc_sequencer #(
  parameter int          NCH      = 7,
  parameter int          AW       = 12,
  parameter logic [31:0] MEM_BASE = 32'hA000_0000,
  parameter logic [31:0] MEM_SIZE = 32'h0400_0000,
  localparam int         CW       = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_start,
  input  logic          lcd_enable,
  input  logic          dual_scan,
  input  logic          ovl1_enable,
  input  logic          ovl2_enable,
  input  logic          cursor_enable,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_waddr,
  input  logic [31:0]   reg_wdata,
  input  logic [AW-1:0] reg_raddr,
  output logic [31:0]   reg_rdata,
  output logic          mem_req,
  output logic [31:0]   mem_addr,
  input  logic          mem_rvalid,
  input  logic [31:0]   mem_rdata,
  output logic          busy,
  output logic          done,
  output logic          evt_branch,
  output logic          evt_buserr,
  output logic          evt_palette,
  output logic [CW-1:0] evt_chan
);
  localparam int          DESC_BASE = 'h200;
  localparam int          BRCH_BASE = 'h040;
  localparam logic [32:0] MEM_LIM   = {1'b0, MEM_BASE} + {1'b0, MEM_SIZE};
  localparam int          PAL_BIT   = 26;

  typedef enum logic [2:0] {S_IDLE, S_SEL, S_REQ, S_WAIT, S_CHECK} state_t;

  state_t        state;
  logic [CW-1:0] ch;
  logic [1:0]    word;
  logic [31:0]   ptr;
  logic [31:0]   nda [NCH];
  logic [31:0]   src [NCH];
  logic [31:0]   fid [NCH];
  logic [31:0]   cmd [NCH];
  logic [31:0]   bra [NCH];
  logic [NCH-1:0] act;

  for (genvar i = 0; i < NCH; i++) begin : g_act
    if (i == 0)             begin : g_c0  assign act[i] = lcd_enable;                end
    else if (i == 1)        begin : g_c1  assign act[i] = ovl1_enable | dual_scan;    end
    else if (i <= 4)        begin : g_ov2 assign act[i] = ovl2_enable;                end
    else if (i == 5)        begin : g_cur assign act[i] = cursor_enable;              end
    else                    begin : g_off assign act[i] = 1'b0;                       end
  end

  wire        armed   = bra[ch][0];
  wire [31:0] sel_ptr = armed ? {bra[ch][31:4], 4'h0} : nda[ch];
  wire        fits    = (sel_ptr >= MEM_BASE) && ({1'b0, sel_ptr} + 33'd16 <= MEM_LIM);
  wire [31:0] cur_src = src[ch];
  wire        src_ok  = (cur_src != 32'h0) && (cur_src >= MEM_BASE) && ({1'b0, cur_src} <= MEM_LIM);
  wire        last_ch = (ch == CW'(NCH - 1));

  assign busy     = (state != S_IDLE);
  assign mem_req  = (state == S_REQ);
  assign mem_addr = ptr + {28'h0, word, 2'b00};

  always_comb begin
    reg_rdata = 32'h0;
    for (int i = 0; i < NCH; i++) begin
      if (reg_raddr == AW'(DESC_BASE + 16*i))      reg_rdata = nda[i];
      if (reg_raddr == AW'(DESC_BASE + 16*i + 4))  reg_rdata = src[i];
      if (reg_raddr == AW'(DESC_BASE + 16*i + 8))  reg_rdata = fid[i];
      if (reg_raddr == AW'(DESC_BASE + 16*i + 12)) reg_rdata = cmd[i];
      if (reg_raddr == AW'(BRCH_BASE + 4*i))       reg_rdata = bra[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      ch          <= '0;
      word        <= '0;
      ptr         <= '0;
      done        <= 1'b0;
      evt_branch  <= 1'b0;
      evt_buserr  <= 1'b0;
      evt_palette <= 1'b0;
      evt_chan    <= '0;
      for (int i = 0; i < NCH; i++) begin
        nda[i] <= '0; src[i] <= '0; fid[i] <= '0; cmd[i] <= '0; bra[i] <= '0;
      end
    end else begin
      done        <= 1'b0;
      evt_branch  <= 1'b0;
      evt_buserr  <= 1'b0;
      evt_palette <= 1'b0;

      if (reg_we) begin
        for (int i = 0; i < NCH; i++) begin
          if (reg_waddr == AW'(DESC_BASE + 16*i)) nda[i] <= reg_wdata & 32'hffff_fff0;
          if (reg_waddr == AW'(BRCH_BASE + 4*i))  bra[i] <= reg_wdata & 32'hffff_fff3;
        end
      end

      case (state)
        S_IDLE: if (frame_start) begin
          ch    <= '0;
          state <= S_SEL;
        end
        S_SEL: begin
          src[ch] <= '0;
          word    <= '0;
          if (!act[ch]) begin
            if (last_ch) begin state <= S_IDLE; done <= 1'b1; end
            else ch <= ch + 1'b1;
          end else begin
            ptr <= sel_ptr;
            if (armed) begin
              bra[ch][0] <= 1'b0;
              if (bra[ch][1]) begin
                evt_branch <= 1'b1;
                evt_chan   <= ch;
              end
            end
            state <= fits ? S_REQ : S_CHECK;
          end
        end
        S_REQ: state <= S_WAIT;
        S_WAIT: if (mem_rvalid) begin
          case (word)
            2'd0: nda[ch] <= mem_rdata;
            2'd1: src[ch] <= mem_rdata;
            2'd2: fid[ch] <= mem_rdata;
            default: cmd[ch] <= mem_rdata;
          endcase
          if (word == 2'd3) state <= S_CHECK;
          else begin
            word  <= word + 1'b1;
            state <= S_REQ;
          end
        end
        S_CHECK: begin
          if (!src_ok) begin
            evt_buserr <= 1'b1;
            evt_chan   <= ch;
          end else if (cmd[ch][PAL_BIT]) begin
            evt_palette <= 1'b1;
            evt_chan    <= ch;
          end
          if (last_ch) begin state <= S_IDLE; done <= 1'b1; end
          else begin
            ch    <= ch + 1'b1;
            state <= S_SEL;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fdesc_sequencer_chk.sv
module fdesc_sequencer_chk #(
  parameter logic [31:0] MEM_BASE = 32'hA000_0000,
  parameter logic [31:0] MEM_SIZE = 32'h0400_0000
) (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_req,
  input logic [31:0] mem_addr,
  input logic        busy,
  input logic        done,
  input logic        evt_branch,
  input logic        evt_buserr,
  input logic        evt_palette
);
  localparam logic [32:0] LIM = {1'b0, MEM_BASE} + {1'b0, MEM_SIZE};

  a_r2_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[1:0] == 2'b00));

  a_r2_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  a_r6_req_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr >= MEM_BASE && {1'b0, mem_addr} < LIM));

  a_r10_one_event: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({evt_branch, evt_buserr, evt_palette}));

  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);
endmodule

bind fdesc_sequencer fdesc_sequencer_chk #(.MEM_BASE(MEM_BASE), .MEM_SIZE(MEM_SIZE)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_addr(mem_addr),
  .busy(busy), .done(done), .evt_branch(evt_branch),
  .evt_buserr(evt_buserr), .evt_palette(evt_palette)
);

// File: tb/tb_fdesc_sequencer.sv
module tb_fdesc_sequencer;
  localparam int          CLK_PERIOD = 10;
  localparam int          NCH  = 7;
  localparam int          AW   = 12;
  localparam int          CW   = 3;
  localparam logic [31:0] BASE = 32'h0000_1000;
  localparam logic [31:0] SIZE = 32'h0000_1000;

  logic clk = 0, rst_n = 0, frame_start = 0;
  logic lcd_enable = 0, dual_scan = 0, ovl1_enable = 0, ovl2_enable = 0, cursor_enable = 0;
  logic reg_we = 0;
  logic [AW-1:0] reg_waddr = '0, reg_raddr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic mem_req, mem_rvalid = 0;
  logic [31:0] mem_addr, mem_rdata = '0;
  logic busy, done, evt_branch, evt_buserr, evt_palette;
  logic [CW-1:0] evt_chan;

  fdesc_sequencer #(.NCH(NCH), .AW(AW), .MEM_BASE(BASE), .MEM_SIZE(SIZE)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [31:0] mem [1024];
  always @(posedge clk) begin
    mem_rvalid <= mem_req;
    mem_rdata  <= mem[10'((mem_addr - BASE) >> 2)];
  end

  int errors = 0, checks = 0;
  int nreq = 0, ndone = 0, nev = 0;
  logic [31:0] first_addr, last_addr;
  int ev_kind [32];
  int ev_ch [32];

  always @(negedge clk) if (rst_n) begin
    if (mem_req) begin
      if (nreq == 0) first_addr = mem_addr;
      last_addr = mem_addr;
      nreq++;
    end
    if (done) ndone++;
    if ((evt_branch || evt_buserr || evt_palette) && nev < 32) begin
      ev_kind[nev] = evt_branch ? 1 : (evt_buserr ? 2 : 3);
      ev_ch[nev]   = int'(evt_chan);
      nev++;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_waddr = AW'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd_chk(input int a, input logic [31:0] exp, input string tag);
    reg_raddr = AW'(a);
    #1;
    chk(reg_rdata == exp, tag, reg_rdata, exp);
  endtask

  task automatic put_desc(input logic [31:0] a, input logic [31:0] w0, input logic [31:0] w1,
                          input logic [31:0] w2, input logic [31:0] w3);
    mem[10'((a - BASE) >> 2)]     = w0;
    mem[10'((a - BASE) >> 2) + 1] = w1;
    mem[10'((a - BASE) >> 2) + 2] = w2;
    mem[10'((a - BASE) >> 2) + 3] = w3;
  endtask

  task automatic run_frame();
    nreq = 0; ndone = 0; nev = 0;
    @(negedge clk); frame_start = 1;
    @(negedge clk); frame_start = 0;
    for (int k = 0; k < 400 && ndone == 0; k++) @(negedge clk);
    @(negedge clk);
    chk(ndone == 1, "R10 done pulses once", ndone, 1);
  endtask

  task automatic test_reset();
    chk(!busy && !done && !mem_req, "R1 idle after reset", {busy, done, mem_req}, 0);
    chk(!evt_branch && !evt_buserr && !evt_palette, "R1 no events", {evt_branch, evt_buserr, evt_palette}, 0);
    rd_chk('h200, 0, "R1 next reg zero");
    rd_chk('h234, 0, "R1 source reg zero");
    rd_chk('h040, 0, "R1 branch reg zero");
  endtask

  task automatic test_basic();
    put_desc(32'h1100, 32'h1200, 32'h1800, 32'hCAFE0001, 32'h0060_0040);
    wr('h200, 32'h0000_110C);
    rd_chk('h200, 32'h1100, "R7 next-descriptor masked");
    lcd_enable = 1;
    run_frame();
    chk(nreq == 4, "R2 four reads", nreq, 4);
    chk(first_addr == 32'h1100, "R2 first address", first_addr, 32'h1100);
    chk(last_addr == 32'h110C, "R2 last address", last_addr, 32'h110C);
    rd_chk('h200, 32'h1200, "R2 next stored");
    rd_chk('h204, 32'h1800, "R2 source stored");
    rd_chk('h208, 32'hCAFE0001, "R2 frame id stored");
    rd_chk('h20C, 32'h0060_0040, "R8 command stored, enables no effect");
    chk(nev == 0, "R8 valid source no event", nev, 0);
    rd_chk('h214, 0, "R3 inactive source zero");
  endtask

  task automatic test_chain();
    put_desc(32'h1200, 32'h1100, 32'h1900, 32'hCAFE0002, 32'h0400_0010);
    run_frame();
    chk(first_addr == 32'h1200, "R5 chained pointer", first_addr, 32'h1200);
    rd_chk('h208, 32'hCAFE0002, "R5 chained frame id");
    chk(nev == 1 && ev_kind[0] == 3 && ev_ch[0] == 0, "R8 palette event ch0", nev, 1);
  endtask

  task automatic test_branch();
    put_desc(32'h13F0, 32'h1300, 32'h1A00, 32'hB000_0003, 32'h0);
    wr('h040, 32'h0000_13F7);
    rd_chk('h040, 32'h13F3, "R7 branch masked");
    run_frame();
    chk(first_addr == 32'h13F0, "R4 branch pointer used", first_addr, 32'h13F0);
    rd_chk('h040, 32'h13F2, "R4 branch flag cleared");
    rd_chk('h200, 32'h1300, "R4 next from branch desc");
    chk(nev == 1 && ev_kind[0] == 1 && ev_ch[0] == 0, "R4 branch event", nev, 1);
    wr('h040, 32'h0000_1101);
    run_frame();
    chk(first_addr == 32'h1100, "R4 silent branch pointer", first_addr, 32'h1100);
    chk(nev == 0, "R4 no event without interrupt bit", nev, 0);
    rd_chk('h040, 32'h1100, "R4 silent branch cleared");
  endtask

  task automatic test_window();
    put_desc(32'h1FF0, 32'h2000, 32'h1C00, 32'h5, 32'h0);
    wr('h200, 32'h1FF0);
    run_frame();
    chk(nreq == 4 && first_addr == 32'h1FF0, "R6 top-edge descriptor fetched", nreq, 4);
    run_frame();
    chk(nreq == 0, "R6 pointer at limit not fetched", nreq, 0);
    rd_chk('h204, 0, "R6 source left zero");
    chk(nev == 1 && ev_kind[0] == 2 && ev_ch[0] == 0, "R6 bus error", nev, 1);
    wr('h200, 32'h0FF0);
    run_frame();
    chk(nreq == 0 && nev == 1 && ev_kind[0] == 2, "R6 below base", nreq, 0);
  endtask

  task automatic test_source();
    put_desc(32'h1400, 32'h1410, 32'h0,    32'h6, 32'h0);
    put_desc(32'h1410, 32'h1420, 32'h2000, 32'h7, 32'h0400_0000);
    put_desc(32'h1420, 32'h1400, 32'h2004, 32'h8, 32'h0400_0000);
    wr('h200, 32'h1400);
    run_frame();
    chk(nev == 1 && ev_kind[0] == 2, "R8 zero source bus error", nev, 1);
    run_frame();
    chk(nev == 1 && ev_kind[0] == 3, "R8 source at upper bound valid", ev_kind[0], 3);
    run_frame();
    chk(nev == 1 && ev_kind[0] == 2, "R8 source past bound, no palette", ev_kind[0], 2);
  endtask

  task automatic test_mapping();
    wr('h200, 32'h0);
    lcd_enable = 1; ovl2_enable = 1; cursor_enable = 1;
    run_frame();
    chk(nreq == 0, "R9 no fetch", nreq, 0);
    chk(nev == 5, "R9 five active channels", nev, 5);
    chk(ev_ch[0] == 0 && ev_ch[1] == 2 && ev_ch[2] == 3 && ev_ch[3] == 4 && ev_ch[4] == 5,
        "R10 ascending order", ev_ch[4], 5);
    lcd_enable = 0; ovl2_enable = 0; cursor_enable = 0; dual_scan = 1;
    run_frame();
    chk(nev == 1 && ev_ch[0] == 1, "R9 dual scan ch1", ev_ch[0], 1);
    dual_scan = 0; ovl1_enable = 1;
    run_frame();
    chk(nev == 1 && ev_ch[0] == 1, "R9 overlay1 ch1", ev_ch[0], 1);
    ovl1_enable = 0;
    put_desc(32'h1500, 32'h1500, 32'h1800, 32'h9, 32'h0);
    wr('h200, 32'h1500); lcd_enable = 1;
    run_frame();
    rd_chk('h204, 32'h1800, "R3 source set while active");
    lcd_enable = 0;
    run_frame();
    chk(nreq == 0 && nev == 0, "R3 all inactive quiet", nreq, 0);
    rd_chk('h204, 0, "R3 source cleared when inactive");
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    test_reset();
    test_basic();
    test_chain();
    test_branch();
    test_window();
    test_source();
    test_mapping();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule